// File: doc/BRIEF.md
# Sideband Mailbox Bridge

This block gives a host processor a small register window through which it can run one register transaction at a time on an internal sideband fabric. The host first programs a target address and, for writes, a data word. It then writes a control word (the doorbell) that names the destination port, the opcode, byte enables, a device/function code and a BAR selector, with its low bit set to launch the request. The bridge decodes the opcode, sends a single request over a valid/ready channel and waits for the matching response.

When the response arrives, the bridge clears the busy bit. For a read it first stores the returned word into the data register, so the host can poll busy and then read the data. A response that does not arrive within a programmable number of cycles aborts the transaction and sets a sticky timeout flag. An opcode the bridge does not support finishes at once, issues no request and sets a sticky error flag.

Back-pressure on the request channel works as follows. Once raised, `sb_req_valid` and its payload stay constant until a cycle in which `sb_req_ready` is high. The only exception is a timeout abort, which withdraws the request. The response channel has no back-pressure: `sb_rsp_valid` is a one-cycle pulse, and the bridge accepts it only while it is waiting for a completion.

Top module: `sbmbx_bridge`

## Requirements
- R1: After reset, every host register reads zero, busy is 0 and `sb_req_valid` is low.
- R2: Host register offsets are: address at 0x0, data at 0x4, doorbell at 0x8, status at 0xC. Other offsets read zero and ignore writes. Doorbell layout: bit 0 busy, [7:4] byte enables, [10:8] BAR, [15:11] device/function, [23:16] port, [31:24] opcode. Bits [3:1] read zero. A doorbell write with bit 0 clear only stores the fields and issues nothing.
- R3: A doorbell write with bit 0 set and opcode 0x00, 0x01, 0x06 or 0x07 raises `sb_req_valid` in the next cycle. The request carries the stored port, opcode, address and byte enables, and it is held stable until `sb_req_ready` is high.
- R4: Opcodes 0x00 and 0x06 are reads and send request data zero. Opcodes 0x01 and 0x07 are writes and send the data register.
- R5: Each doorbell produces exactly one request. After the handshake, `sb_req_valid` stays low until the next doorbell, and it is never high while busy is 0.
- R6: A response accepted while waiting clears busy at that same clock edge. A read loads `sb_rsp_data` into the data register. A write leaves the data register unchanged.
- R7: While busy is 1, host writes to the address, data and doorbell registers are ignored. In particular, no second request is started.
- R8: A doorbell write with bit 0 set and any other opcode issues no request, leaves busy at 0 and sets status bit 1.
- R9: A response with `sb_rsp_err` high sets status bit 1.
- R10: When `tmo_limit` is N (N not 0) and no response is accepted, busy clears at the Nth clock edge after the doorbell edge. At that point status bit 0 is set and `sb_req_valid` is low. When `tmo_limit` is 0, there is no timeout.
- R11: Status bits 0 (timeout) and 1 (error) are sticky. Writing 1 to a bit at offset 0xC clears that bit, and writing 0 leaves it unchanged.
- R12: A response pulse while the bridge is idle has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hwr_en | input | 1 | Host write strobe |
| hwr_ofs | input | HOFS_W | Host write offset |
| hwr_data | input | 32 | Host write data |
| hrd_ofs | input | HOFS_W | Host read offset |
| hrd_data | output | 32 | Host read data (combinational) |
| tmo_limit | input | TMO_W | Response timeout in cycles, 0 disables |
| sb_req_valid | output | 1 | Sideband request valid |
| sb_req_ready | input | 1 | Sideband request ready |
| sb_req_port | output | 8 | Destination port |
| sb_req_opc | output | 8 | Opcode |
| sb_req_addr | output | 32 | Target address |
| sb_req_data | output | 32 | Write data (zero for reads) |
| sb_req_be | output | 4 | Byte enables |
| sb_rsp_valid | input | 1 | Response pulse |
| sb_rsp_data | input | 32 | Response read data |
| sb_rsp_err | input | 1 | Response error flag |

## Verification
The assertions rely on three assumptions about the environment. First, `tmo_limit` stays unchanged while a transaction is in flight; the bound on busy duration is measured against it. Second, the fabric returns at most one single-cycle response per request. Third, the fabric never responds before it has accepted the request. The stimulus changes the limit only between transactions and drives every response as a one-cycle pulse after the handshake. The one exception is a deliberate pulse sent while idle, which checks that such a pulse is ignored.

// File: rtl/sbmbx_pkg.sv
package sbmbx_pkg;
  localparam logic [7:0] OPC_MRD = 8'h00;
  localparam logic [7:0] OPC_MWR = 8'h01;
  localparam logic [7:0] OPC_PRD = 8'h06;
  localparam logic [7:0] OPC_PWR = 8'h07;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_st_e;

  typedef struct packed {
    logic [7:0] opc;
    logic [7:0] port;
    logic [4:0] devfn;
    logic [2:0] bar;
    logic [3:0] be;
  } dbell_t;

  function automatic dbell_t dbell_unpack(input logic [31:0] w);
    dbell_t d;
    d.opc   = w[31:24];
    d.port  = w[23:16];
    d.devfn = w[15:11];
    d.bar   = w[10:8];
    d.be    = w[7:4];
    return d;
  endfunction

  function automatic logic [31:0] dbell_pack(input dbell_t d, input logic busy);
    return {d.opc, d.port, d.devfn, d.bar, d.be, 3'b000, busy};
  endfunction
endpackage

// File: rtl/sbmbx_opdec.sv
module sbmbx_opdec
  import sbmbx_pkg::*;
(
  input  logic [7:0] opc,
  output logic       ok,
  output logic       rd
);
  always_comb begin
    ok = (opc == OPC_MRD) || (opc == OPC_MWR) || (opc == OPC_PRD) || (opc == OPC_PWR);
    rd = (opc == OPC_MRD) || (opc == OPC_PRD);
  end
endmodule

// File: rtl/sbmbx_seq.sv
module sbmbx_seq
  import sbmbx_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output logic             req_valid,
  output logic             busy,
  output logic             rsp_take,
  output logic             tmo_fire
);
  localparam int CW = TMO_W + 1;

  seq_st_e          st_q;
  logic [TMO_W-1:0] cnt_q;
  logic             cnt_last;

  always_comb begin
    req_valid = (st_q == ST_REQ);
    busy      = (st_q != ST_IDLE);
    rsp_take  = (st_q == ST_WAIT) && rsp_valid;
    cnt_last  = ({1'b0, cnt_q} + CW'(1)) == {1'b0, tmo_limit};
    tmo_fire  = busy && (tmo_limit != '0) && cnt_last && !rsp_take;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q  <= ST_REQ;
            cnt_q <= '0;
          end
        end
        ST_REQ: begin
          cnt_q <= cnt_q + 1'b1;
          if (tmo_fire)       st_q <= ST_IDLE;
          else if (req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          cnt_q <= cnt_q + 1'b1;
          if (rsp_take || tmo_fire) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbmbx_bridge.sv
module sbmbx_bridge
  import sbmbx_pkg::*;
#(
  parameter int HOFS_W = 4,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hwr_en,
  input  logic [HOFS_W-1:0] hwr_ofs,
  input  logic [31:0]       hwr_data,
  input  logic [HOFS_W-1:0] hrd_ofs,
  output logic [31:0]       hrd_data,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              sb_req_valid,
  input  logic              sb_req_ready,
  output logic [7:0]        sb_req_port,
  output logic [7:0]        sb_req_opc,
  output logic [31:0]       sb_req_addr,
  output logic [31:0]       sb_req_data,
  output logic [3:0]        sb_req_be,
  input  logic              sb_rsp_valid,
  input  logic [31:0]       sb_rsp_data,
  input  logic              sb_rsp_err
);
  localparam logic [HOFS_W-1:0] OFS_ADDR = HOFS_W'(4'h0);
  localparam logic [HOFS_W-1:0] OFS_DATA = HOFS_W'(4'h4);
  localparam logic [HOFS_W-1:0] OFS_DBEL = HOFS_W'(4'h8);
  localparam logic [HOFS_W-1:0] OFS_STAT = HOFS_W'(4'hC);

  logic [31:0] addr_q, data_q;
  dbell_t      db_q;
  logic        st_tmo_q, st_err_q;
  logic        busy, rsp_take, tmo_fire;
  logic        in_ok, in_rd, cur_ok, cur_rd;
  logic        wr_addr, wr_data, wr_dbel, wr_stat;
  logic        start, bad_opc;
  logic [31:0] db_rd;

  sbmbx_opdec u_dec_in (.opc(hwr_data[31:24]), .ok(in_ok), .rd(in_rd));
  sbmbx_opdec u_dec_cur (.opc(db_q.opc), .ok(cur_ok), .rd(cur_rd));

  sbmbx_seq #(.TMO_W(TMO_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tmo_limit(tmo_limit),
    .req_ready(sb_req_ready),
    .rsp_valid(sb_rsp_valid),
    .req_valid(sb_req_valid),
    .busy     (busy),
    .rsp_take (rsp_take),
    .tmo_fire (tmo_fire)
  );

  always_comb begin
    wr_addr = hwr_en && (hwr_ofs == OFS_ADDR) && !busy;
    wr_data = hwr_en && (hwr_ofs == OFS_DATA) && !busy;
    wr_dbel = hwr_en && (hwr_ofs == OFS_DBEL) && !busy;
    wr_stat = hwr_en && (hwr_ofs == OFS_STAT);
    start   = wr_dbel && hwr_data[0] && in_ok;
    bad_opc = wr_dbel && hwr_data[0] && !in_ok;
    db_rd   = dbell_pack(db_q, busy);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      data_q   <= '0;
      db_q     <= '0;
      st_tmo_q <= 1'b0;
      st_err_q <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= hwr_data;
      if (rsp_take && cur_rd) data_q <= sb_rsp_data;
      else if (wr_data)       data_q <= hwr_data;
      if (wr_dbel) db_q <= dbell_unpack(hwr_data);
      st_tmo_q <= tmo_fire | (st_tmo_q & ~(wr_stat & hwr_data[0]));
      st_err_q <= bad_opc | (rsp_take & sb_rsp_err) | (st_err_q & ~(wr_stat & hwr_data[1]));
    end
  end

  always_comb begin
    unique case (hrd_ofs)
      OFS_ADDR: hrd_data = addr_q;
      OFS_DATA: hrd_data = data_q;
      OFS_DBEL: hrd_data = db_rd;
      OFS_STAT: hrd_data = {30'd0, st_err_q, st_tmo_q};
      default:  hrd_data = '0;
    endcase
  end

  always_comb begin
    sb_req_port = db_q.port;
    sb_req_opc  = db_q.opc;
    sb_req_addr = addr_q;
    sb_req_be   = db_q.be;
    sb_req_data = cur_rd ? 32'd0 : data_q;
  end

  logic unused_ok;
  assign unused_ok = cur_ok & in_rd;
endmodule

// File: rtl/sbmbx_chk.sv
module sbmbx_chk #(
  parameter int HOFS_W = 4,
  parameter int TMO_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic [7:0]        req_opc,
  input logic [31:0]       req_data,
  input logic              hwr_en,
  input logic [HOFS_W-1:0] hwr_ofs,
  input logic [31:0]       hwr_data,
  input logic              st_err,
  input logic [TMO_W-1:0]  tmo_limit,
  input logic [31:0]       db_word
);
  localparam int CW = TMO_W + 1;
  logic [CW-1:0] busy_cnt;
  logic          in_sup;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= '0;
    else if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
  end

  always_comb in_sup = (hwr_data[31:24] == 8'h00) || (hwr_data[31:24] == 8'h01) ||
                       (hwr_data[31:24] == 8'h06) || (hwr_data[31:24] == 8'h07);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid || !busy));

  p_rd_data_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_opc == 8'h00 || req_opc == 8'h06)) |-> (req_data == 32'd0));

  p_one_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hwr_en && hwr_ofs == HOFS_W'(4'h8)) |=> $stable(db_word[31:1]));

  p_bad_opc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hwr_en && hwr_ofs == HOFS_W'(4'h8) && hwr_data[0] && !busy && !in_sup) |=> (!busy && st_err));

  p_tmo_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmo_limit != '0) |-> (busy_cnt < {1'b0, tmo_limit}));
endmodule

bind sbmbx_bridge sbmbx_chk #(.HOFS_W(HOFS_W), .TMO_W(TMO_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .req_valid(sb_req_valid),
  .req_ready(sb_req_ready),
  .req_opc  (sb_req_opc),
  .req_data (sb_req_data),
  .hwr_en   (hwr_en),
  .hwr_ofs  (hwr_ofs),
  .hwr_data (hwr_data),
  .st_err   (st_err_q),
  .tmo_limit(tmo_limit),
  .db_word  (db_rd)
);

// File: tb/tb_sbmbx_bridge.sv
module tb_sbmbx_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hwr_en = 1'b0;
  logic [3:0]  hwr_ofs = '0;
  logic [31:0] hwr_data = '0;
  logic [3:0]  hrd_ofs = '0;
  logic [31:0] hrd_data;
  logic [7:0]  tmo_limit = 8'd40;
  logic        sb_req_valid;
  logic        sb_req_ready = 1'b0;
  logic [7:0]  sb_req_port, sb_req_opc;
  logic [31:0] sb_req_addr, sb_req_data;
  logic [3:0]  sb_req_be;
  logic        sb_rsp_valid = 1'b0;
  logic [31:0] sb_rsp_data = '0;
  logic        sb_rsp_err = 1'b0;

  int total = 0;
  int bad = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  sbmbx_bridge dut (
    .clk(clk), .rst_n(rst_n), .hwr_en(hwr_en), .hwr_ofs(hwr_ofs), .hwr_data(hwr_data),
    .hrd_ofs(hrd_ofs), .hrd_data(hrd_data), .tmo_limit(tmo_limit),
    .sb_req_valid(sb_req_valid), .sb_req_ready(sb_req_ready), .sb_req_port(sb_req_port),
    .sb_req_opc(sb_req_opc), .sb_req_addr(sb_req_addr), .sb_req_data(sb_req_data),
    .sb_req_be(sb_req_be), .sb_rsp_valid(sb_rsp_valid), .sb_rsp_data(sb_rsp_data),
    .sb_rsp_err(sb_rsp_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [3:0] ofs, input logic [31:0] d);
    @(negedge clk);
    hwr_en = 1'b1; hwr_ofs = ofs; hwr_data = d;
    @(negedge clk);
    hwr_en = 1'b0;
  endtask

  task automatic hread(input logic [3:0] ofs, output logic [31:0] d);
    hrd_ofs = ofs;
    #1;
    d = hrd_data;
  endtask

  function automatic logic [31:0] mk_db(input logic [7:0] opc, input logic [7:0] port,
                                        input logic [4:0] dfn, input logic [2:0] bar,
                                        input logic [3:0] be, input logic go);
    return {opc, port, dfn, bar, be, 3'b000, go};
  endfunction

  task automatic busy_is(input string req, input logic exp);
    logic [31:0] d;
    hread(4'h8, d);
    check(req, {31'd0, d[0]}, {31'd0, exp});
  endtask

  task automatic txn(input logic [7:0] opc, input int idx, input int rdly, input int pdly);
    logic [31:0] wd, rdat, d;
    logic [31:0] ad;
    logic        rd, er;
    wd   = 32'hA500_0000 ^ (idx * 32'h0101_0101);
    rdat = ~wd ^ 32'(idx);
    ad   = 32'h0000_1000 + 32'(idx * 4);
    rd   = (opc == 8'h00) || (opc == 8'h06);
    er   = (idx % 5) == 0;
    hwrite(4'h0, ad);
    hwrite(4'h4, wd);
    hwrite(4'h8, mk_db(opc, 8'(idx + 3), 5'(idx), 3'(idx), 4'(idx), 1'b1));
    check("R3 valid", {31'd0, sb_req_valid}, 32'd1);
    check("R3 port", {24'd0, sb_req_port}, 32'(8'(idx + 3)));
    check("R3 opc", {24'd0, sb_req_opc}, {24'd0, opc});
    check("R3 addr", sb_req_addr, ad);
    check("R3 be", {28'd0, sb_req_be}, {28'd0, 4'(idx)});
    check("R4 data", sb_req_data, rd ? 32'd0 : wd);
    repeat (rdly) @(negedge clk);
    check("R3 hold", {31'd0, sb_req_valid}, 32'd1);
    sb_req_ready = 1'b1;
    @(negedge clk);
    sb_req_ready = 1'b0;
    check("R5 drop", {31'd0, sb_req_valid}, 32'd0);
    busy_is("R5 busy", 1'b1);
    repeat (pdly) @(negedge clk);
    check("R5 quiet", {31'd0, sb_req_valid}, 32'd0);
    sb_rsp_valid = 1'b1; sb_rsp_data = rdat; sb_rsp_err = er;
    @(negedge clk);
    sb_rsp_valid = 1'b0; sb_rsp_err = 1'b0;
    busy_is("R6 busy", 1'b0);
    hread(4'h4, d);
    check("R6 data", d, rd ? rdat : wd);
    hread(4'hC, d);
    check("R9 err", d, {30'd0, er, 1'b0});
    hwrite(4'hC, 32'h3);
  endtask

  initial begin
    #(150000 * 10);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int o = 0; o < 16; o += 4) begin
      hread(4'(o), v);
      check("R1 reg", v, 32'd0);
    end
    check("R1 valid", {31'd0, sb_req_valid}, 32'd0);

    // R2 doorbell fields without launch
    hwrite(4'h8, 32'hFFFF_FFFE);
    hread(4'h8, v);
    check("R2 dbell", v, 32'hFFFF_FFF0);
    check("R2 noreq", {31'd0, sb_req_valid}, 32'd0);
    hwrite(4'h2, 32'h1234_5678);
    hread(4'h2, v);
    check("R2 hole", v, 32'd0);
    hread(4'h0, v);
    check("R2 addr", v, 32'd0);

    // R3 R4 R5 R6 R9 sweep over opcodes and delays
    for (int k = 0; k < 64; k++) begin
      logic [7:0] op;
      op = (k % 4 == 0) ? 8'h00 : (k % 4 == 1) ? 8'h01 : (k % 4 == 2) ? 8'h06 : 8'h07;
      txn(op, k, (k / 4) % 4, (k / 16) % 4);
    end

    // R8 every unsupported opcode
    for (int op = 0; op < 256; op++) begin
      if (!(op == 0 || op == 1 || op == 6 || op == 7)) begin
        hwrite(4'h8, mk_db(8'(op), 8'h11, 5'd2, 3'd1, 4'hF, 1'b1));
        check("R8 noreq", {31'd0, sb_req_valid}, 32'd0);
        busy_is("R8 busy", 1'b0);
        hread(4'hC, v);
        check("R8 err", v, 32'h2);
        hwrite(4'hC, 32'h2);
      end
    end

    // R7 writes while busy ignored
    hwrite(4'h0, 32'hCAFE_0000);
    hwrite(4'h4, 32'h0000_BEEF);
    hwrite(4'h8, mk_db(8'h07, 8'h22, 5'd1, 3'd0, 4'hF, 1'b1));
    hwrite(4'h0, 32'h1111_1111);
    hwrite(4'h4, 32'h2222_2222);
    hwrite(4'h8, mk_db(8'h00, 8'h33, 5'd1, 3'd0, 4'h1, 1'b1));
    hread(4'h0, v); check("R7 addr", v, 32'hCAFE_0000);
    hread(4'h4, v); check("R7 data", v, 32'h0000_BEEF);
    check("R7 opc", {24'd0, sb_req_opc}, 32'h07);
    check("R7 port", {24'd0, sb_req_port}, 32'h22);
    sb_req_ready = 1'b1; @(negedge clk); sb_req_ready = 1'b0;
    sb_rsp_valid = 1'b1; sb_rsp_data = 32'h5555_5555; @(negedge clk); sb_rsp_valid = 1'b0;
    busy_is("R7 done", 1'b0);
    hread(4'h4, v); check("R6 wr keep", v, 32'h0000_BEEF);

    // R12 idle response ignored
    sb_rsp_valid = 1'b1; sb_rsp_data = 32'h9999_9999; sb_rsp_err = 1'b1;
    @(negedge clk);
    sb_rsp_valid = 1'b0; sb_rsp_err = 1'b0;
    hread(4'h4, v); check("R12 data", v, 32'h0000_BEEF);
    hread(4'hC, v); check("R12 stat", v, 32'd0);
    busy_is("R12 busy", 1'b0);

    // R10 timeout with ready never given
    for (int n = 1; n <= 5; n++) begin
      tmo_limit = 8'(n);
      hwrite(4'h8, mk_db(8'h06, 8'h44, 5'd0, 3'd0, 4'hF, 1'b1));
      repeat (n - 1) @(negedge clk);
      busy_is("R10 before", 1'b1);
      @(negedge clk);
      busy_is("R10 at", 1'b0);
      check("R10 valid", {31'd0, sb_req_valid}, 32'd0);
      hread(4'hC, v); check("R10 stat", v, 32'h1);
      hwrite(4'hC, 32'h1);
    end
    // R10 timeout while waiting for the response
    tmo_limit = 8'd6;
    hwrite(4'h8, mk_db(8'h01, 8'h45, 5'd0, 3'd0, 4'hF, 1'b1));
    sb_req_ready = 1'b1; @(negedge clk); sb_req_ready = 1'b0;
    repeat (4) @(negedge clk);
    busy_is("R10 wait before", 1'b1);
    @(negedge clk);
    busy_is("R10 wait at", 1'b0);
    // R11 partial clear: write 0 to bit 0 keeps it
    hwrite(4'hC, 32'h2);
    hread(4'hC, v); check("R11 keep", v, 32'h1);
    hwrite(4'hC, 32'h1);
    hread(4'hC, v); check("R11 clear", v, 32'h0);
    // R10 limit 0 disables the timeout
    tmo_limit = 8'd0;
    hwrite(4'h8, mk_db(8'h00, 8'h46, 5'd0, 3'd0, 4'hF, 1'b1));
    repeat (300) @(negedge clk);
    busy_is("R10 off", 1'b1);
    sb_req_ready = 1'b1; @(negedge clk); sb_req_ready = 1'b0;
    sb_rsp_valid = 1'b1; sb_rsp_data = 32'h0BAD_F00D; @(negedge clk); sb_rsp_valid = 1'b0;
    busy_is("R10 off done", 1'b0);
    hread(4'h4, v); check("R6 rd load", v, 32'h0BAD_F00D);
    hread(4'hC, v); check("R11 none", v, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule